// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a test access port for a small group of bidirectional I/O pins. A serial test clock, mode select and data input drive a sixteen-state controller. That controller moves bits through either a 10-bit instruction register or a data register, and returns them on a serial output that has its own enable. Each pin has a boundary cell between the core and the pad. During normal operation the cell passes the core's data and enable through to the pad. Under external test it drives the pad from values that were scanned in earlier.

Three instructions select a data path: sample/preload, external test and bypass. Sample/preload captures the live pad state and loads new drive values without changing the pins. External test then puts those loaded values on the pads immediately. The block also has a programming-busy input. While it is high, both test instructions behave as bypass, so the pins stay under core control and the stored drive values are left alone. An optional active-low asynchronous test reset initialises the port. Holding the mode select high reaches the same reset state.

Top module: `tap_bscan`

## Requirements
- R1: The controller advances on the rising test clock according to the mode select. Five consecutive rising edges with mode select high reach Test-Logic-Reset from any state. The asynchronous test reset also forces Test-Logic-Reset.
- R2: From Test-Logic-Reset, the mode-select sequence 0,1,1,0,0 on five rising edges reaches Shift-IR.
- R3: In Capture-IR the 10-bit instruction shift register loads 0x155. The serial output presents it LSB first (1,0,1,0,...) starting in the first cycle of Shift-IR.
- R4: The serial output and its enable change on the falling test clock. The enable is high only in Shift-IR and Shift-DR.
- R5: In Test-Logic-Reset, and under test reset, the instruction becomes bypass and every output-enable update register is set to 1. Every pad then follows core_out and core_oe.
- R6: Opcodes: external test = 0x00F, sample/preload = 0x005, bypass = 0x3FF. Any other opcode selects the 1-bit bypass register, which captures 0 and delays the serial data by one stage.
- R7: The boundary chain holds 2 bits per pin. Bit 2i captures pad_in[i] and bit 2i+1 captures the inverse of core_oe[i]. Serial input enters bit 2N-1 and the serial output comes from bit 0.
- R8: Under sample/preload, Update-DR loads bit 2i into pin i's data update register and bit 2i+1 into its active-low enable update register. The pads stay under core control.
- R9: Under external test, pad_out[i] is the data update register and pad_oe[i] is the inverse of the enable update register. This holds from Update-IR onward, with no data scan needed.
- R10: While isp_busy is high, external test and sample/preload act as bypass. The pads follow the core and the update registers do not change.
- R11: Update registers load only on the falling clock in Update-DR while a boundary instruction is in effect. A bypass scan leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Enable for tdo |
| isp_busy | input | 1 | In-system programming in progress |
| core_out | input | N_PINS | Core data toward the pads |
| core_oe | input | N_PINS | Core drive enable, active high |
| core_in | output | N_PINS | Pad values returned to the core |
| pad_in | input | N_PINS | Value seen at each pad |
| pad_out | output | N_PINS | Data driven to each pad |
| pad_oe | output | N_PINS | Pad drive enable, active high |

## Verification
The assertions assume that tms, tdi and isp_busy change only between rising test-clock edges. They also assume that isp_busy does not toggle between an Update-DR cycle and the check that follows it. The stimulus changes these inputs one nanosecond after each falling edge and holds isp_busy steady for each whole table entry. The core and pad inputs are set before a capture and are not touched during a scan, so each captured word is defined. Every scan starts from Run-Test/Idle, and the first one starts from Test-Logic-Reset, which keeps the controller path to each checked state known.

// File: rtl/tap_pkg.sv
package tap_pkg;
  parameter int unsigned IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXT    = 10'h00F;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h005;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IR_W-1:0] IR_CAPT   = 10'h155;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  AST_TMS_HOLDS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR)); // R1

  AST_CAPIR_TO_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR && !tms) |=> (state == ST_SH_IR)); // R2
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);
  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sr <= IR_CAPT;
    else if (state == ST_CAP_IR) sr <= IR_CAPT;
    else if (state == ST_SH_IR)  sr <= {tdi, sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir <= OP_BYPASS;
    else if (state == ST_TLR)    ir <= OP_BYPASS;
    else if (state == ST_UPD_IR) ir <= sr;
  end

  assign ir_so = sr[0];

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (sr == IR_CAPT)); // R3
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic clr,
  input  logic cap_en,
  input  logic sh_en,
  input  logic upd_en,
  input  logic drive_test,
  input  logic si,
  output logic so,
  input  logic pad_in,
  input  logic core_out,
  input  logic core_oe,
  output logic pad_out,
  output logic pad_oe
);
  logic [1:0] sh;
  logic       upd_do;
  logic       upd_oe_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     sh <= 2'b10;
    else if (cap_en) sh <= {~core_oe, pad_in};
    else if (sh_en)  sh <= {si, sh[1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_do   <= 1'b0;
      upd_oe_n <= 1'b1;
    end else if (clr) begin
      upd_do   <= 1'b0;
      upd_oe_n <= 1'b1;
    end else if (upd_en) begin
      upd_do   <= sh[0];
      upd_oe_n <= sh[1];
    end
  end

  assign so      = sh[0];
  assign pad_out = drive_test ? upd_do    : core_out;
  assign pad_oe  = drive_test ? ~upd_oe_n : core_oe;
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
  import tap_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              isp_busy,
  input  logic [N_PINS-1:0] core_out,
  input  logic [N_PINS-1:0] core_oe,
  output logic [N_PINS-1:0] core_in,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  logic            sel_bsr;
  logic            ext_on;
  logic            byp;
  logic [N_PINS:0] chain;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
               .ir(ir), .ir_so(ir_so));

  assign sel_bsr = ((ir == OP_EXT) || (ir == OP_SAMPLE)) && !isp_busy;
  assign ext_on  = (ir == OP_EXT) && !isp_busy;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 byp <= 1'b0;
    else if (state == ST_CAP_DR) byp <= 1'b0;
    else if (state == ST_SH_DR)  byp <= tdi;
  end

  assign chain[N_PINS] = tdi;

  for (genvar i = 0; i < N_PINS; i++) begin : g_cell
    bscan_cell u_cell (
      .tck(tck), .trst_n(trst_n), .clr(state == ST_TLR),
      .cap_en(sel_bsr && state == ST_CAP_DR),
      .sh_en(sel_bsr && state == ST_SH_DR),
      .upd_en(sel_bsr && state == ST_UPD_DR),
      .drive_test(ext_on),
      .si(chain[i+1]), .so(chain[i]),
      .pad_in(pad_in[i]), .core_out(core_out[i]), .core_oe(core_oe[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
    );
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo <= ir_so;
      else if (state == ST_SH_DR) tdo <= sel_bsr ? chain[0] : byp;
    end
  end

  assign core_in = pad_in;

  AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_SH_IR && state != ST_SH_DR) |-> !tdo_oe); // R4

  AST_TLR_RELEASES_PINS: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> (pad_oe == core_oe && pad_out == core_out)); // R5

  AST_BUSY_CORE_OWNS_PINS: assert property (@(posedge tck) disable iff (!trst_n)
    isp_busy |-> (pad_oe == core_oe && pad_out == core_out)); // R10

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR) |=> !byp); // R6
endmodule

// File: tb/sim_tap_bscan.sv
`timescale 1ns/1ps
module sim_tap_bscan;
  localparam int N = 4;
  localparam int DW = 2*N;
  localparam logic [9:0] EXT = 10'h00F, SMP = 10'h005, BYP = 10'h3FF;
  localparam int NV = 8;
  // {opcode[22:13], busy[12], pad_in[11:8], scan data[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {SMP,        1'b0, 4'hA, 8'h4D},
    {EXT,        1'b0, 4'h5, 8'h4D},
    {EXT,        1'b0, 4'h3, 8'h00},
    {EXT,        1'b1, 4'h3, 8'hFF},
    {SMP,        1'b1, 4'hC, 8'h55},
    {BYP,        1'b0, 4'h9, 8'hA5},
    {10'h123,    1'b0, 4'h6, 8'h3C},
    {EXT,        1'b0, 4'hF, 8'hAA}
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, isp_busy = 1'b0;
  logic [N-1:0] core_out = 4'b0110, core_oe = 4'b0011, pad_in = 4'h0;
  logic tdo, tdo_oe;
  logic [N-1:0] core_in, pad_out, pad_oe;
  int n_chk = 0, n_err = 0;
  logic last_oe, first_oe, done = 1'b0;

  tap_bscan #(.N_PINS(N)) u0 (.*);

  always #2 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo; last_oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic shift_ir(input logic [9:0] op, output logic [9:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < 10; k++) begin
      step(k == 9, op[k], o); cap[k] = o;
      if (k == 0) first_oe = last_oe;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input logic [DW-1:0] d, output logic [DW-1:0] cap);
    logic o;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < DW; k++) begin
      step(k == DW-1, d[k], o); cap[k] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  function automatic logic [DW-1:0] cap_word(input logic [N-1:0] pi);
    logic [DW-1:0] w;
    for (int i = 0; i < N; i++) begin
      w[2*i] = pi[i]; w[2*i+1] = ~core_oe[i];
    end
    return w;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] icap;
    logic [DW-1:0] dcap, exp_cap, mdl;
    logic [N-1:0] exp_do, exp_oe;
    logic o;
    mdl = {N{2'b10}};
    #5;
    chk("R5 reset tdo_oe", tdo_oe, 0);
    chk("R5 reset pad_oe", pad_oe, core_oe);
    chk("R5 reset pad_out", pad_out, core_out);
    @(negedge tck); #1 trst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(1, 0, o);
    step(0, 0, o);                     // TLR -> RTI, starts 0,1,1,0,0
    for (int v = 0; v < NV; v++) begin
      logic [9:0] op; logic bz; logic [N-1:0] pi; logic [DW-1:0] d; logic act, ext;
      {op, bz, pi, d} = VEC[v];
      isp_busy = bz; pad_in = pi;
      shift_ir(op, icap);
      chk("R3 IR capture", icap, 10'h155);
      if (v == 0) begin
        chk("R2 shift-IR reached", first_oe, 1);
        chk("R4 tdo_oe off after scan", tdo_oe, 0);
      end
      shift_dr(d, dcap);
      act = (op == EXT || op == SMP) && !bz;
      ext = (op == EXT) && !bz;
      exp_cap = act ? cap_word(pi) : {d[DW-2:0], 1'b0};
      chk(act ? "R7 boundary capture" : "R6 R10 bypass capture", dcap, exp_cap);
      if (act) mdl = d;
      for (int i = 0; i < N; i++) begin
        exp_do[i] = mdl[2*i]; exp_oe[i] = ~mdl[2*i+1];
      end
      chk(ext ? "R9 pad_out" : "R8 R10 pad_out", pad_out, ext ? exp_do : core_out);
      chk(ext ? "R9 pad_oe" : "R8 R10 pad_oe", pad_oe, ext ? exp_oe : core_oe);
    end
    // R11: preload, bypass scan, then external test uses preloaded values at once
    isp_busy = 1'b0;
    shift_ir(SMP, icap); shift_dr(8'h4D, dcap);
    chk("R8 sample keeps core pins", pad_oe, core_oe);
    shift_ir(BYP, icap); shift_dr(8'hFF, dcap);
    shift_ir(EXT, icap);
    chk("R9 R11 drive without DR scan pad_out", pad_out, 4'b1011);
    chk("R9 R11 drive without DR scan pad_oe", pad_oe, 4'b1101);
    // R1: five TMS-high cycles from Shift-DR reset the port
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int k = 0; k < 5; k++) step(1, 0, o);
    step(1, 0, o);
    chk("R1 R5 TMS reset pad_oe", pad_oe, core_oe);
    chk("R1 R5 TMS reset pad_out", pad_out, core_out);
    chk("R4 tdo_oe idle", tdo_oe, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule